// File: doc/BRIEF.md
# E-paper panel power and reset sequencer

This block runs on the host side of a serial link to an e-paper timing controller and brings that controller out of power-off in a safe order. It works in the system clock and counts time in pulses of a one-microsecond tick input. After a start request it enables the panel supply and holds every panel-facing line low while the supply settles. It then pulses the controller reset line, keeps chip-select deasserted for a minimum gap and asserts chip-select. When the combined release-to-data budget is met, it tells a frame transmitter that it may begin.

A power-down request enters a supply-hold phase. In that phase the supply stays enabled while all signal lines are low, and the supply is removed afterwards. A power-down request that arrives during bring-up abandons the sequence and goes straight to the hold phase. Every duration is a parameter in tick units. The block drives the serial data and serial clock lines low throughout, because sending data belongs to a separate transmitter.

Top module: `epd_pwr_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is in the off phase: off_o=1 and vcc_en_o, reset_o, cs_o, ready_o, sdata_o and sclk_o are all 0. An asynchronous reset in the middle of a sequence returns the block to this state.
- R2: A start request in the off phase sets vcc_en_o=1. reset_o and cs_o stay 0 for exactly SETUP_US ticks.
- R3: After the supply phase, reset_o=1 and cs_o=1 (line high, chip-select deasserted) for exactly RST_HI_US ticks.
- R4: Next, reset_o=0 and cs_o=1 for exactly RST_LO_US ticks.
- R5: Next, reset_o returns to 1 and cs_o stays 1 for exactly CS_GAP_US ticks.
- R6: Next, cs_o=0 (chip-select asserted) with reset_o=1 for exactly max(CS_LEAD_US, BUDGET_US - CS_GAP_US) ticks. The release-to-ready time is therefore at least BUDGET_US ticks, and the chip-select lead is at least CS_LEAD_US ticks.
- R7: In the ready phase, ready_o=1, vcc_en_o=1, reset_o=1 and cs_o=0. These hold until a power-down request arrives, and start requests have no effect.
- R8: A power-down request in the ready phase gives vcc_en_o=1 with reset_o, cs_o and ready_o all 0 for exactly HOLD_US ticks. The block then returns to the off phase with vcc_en_o=0 and off_o=1.
- R9: A power-down request during any bring-up phase ends that phase early and enters the hold phase of R8, which lasts the full HOLD_US ticks.
- R10: In the off phase a power-down request is ignored, and it wins over a start request in the same cycle. A start request during the hold phase is ignored.
- R11: sdata_o and sclk_o are 0 in every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bring-up request, sampled on the clock |
| pwr_down_i | input | 1 | Power-down request, sampled on the clock |
| tick_us_i | input | 1 | One-cycle pulse per microsecond |
| vcc_en_o | output | 1 | Panel supply enable |
| reset_o | output | 1 | Controller reset line level |
| cs_o | output | 1 | Chip-select line level (low = selected) |
| sdata_o | output | 1 | Serial data line level, held low |
| sclk_o | output | 1 | Serial clock line level, held low |
| ready_o | output | 1 | Frame transmitter may start |
| off_o | output | 1 | Supply removed, sequencer idle |

## Verification
The outputs are decoded from the phase register. A phase therefore changes on the clock edge after the one where its last tick is counted, and the tick that falls on the edge entering a phase is not counted. The bench drives a tick every four clocks and samples on the falling edge. Each output change starts a new phase record, and the bench counts the ticks sampled after that record opened. Each record is then compared with the tick count its requirement gives. Requests are driven two nanoseconds after a falling edge, so each takes effect at exactly the next rising edge.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_SUPPLY,
    PH_RST_HI,
    PH_RST_LO,
    PH_CS_GAP,
    PH_CS_LEAD,
    PH_READY,
    PH_HOLD
  } epd_phase_e;

  typedef struct packed {
    logic vcc;
    logic rst;
    logic cs;
    logic rdy;
    logic off;
  } epd_pins_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/epd_tick_timer.sv
module epd_tick_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/epd_phase_fsm.sv
module epd_phase_fsm
  import epd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       pwr_down_i,
  input  logic       done_i,
  output epd_phase_e phase_o,
  output logic       adv_o
);

  epd_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_OFF:   if (start_i && !pwr_down_i) phase_d = PH_SUPPLY;
      PH_HOLD:  if (done_i) phase_d = PH_OFF;
      PH_READY: if (pwr_down_i) phase_d = PH_HOLD;
      default: begin
        if (pwr_down_i) phase_d = PH_HOLD;
        else if (done_i) begin
          unique case (phase_q)
            PH_SUPPLY:  phase_d = PH_RST_HI;
            PH_RST_HI:  phase_d = PH_RST_LO;
            PH_RST_LO:  phase_d = PH_CS_GAP;
            PH_CS_GAP:  phase_d = PH_CS_LEAD;
            PH_CS_LEAD: phase_d = PH_READY;
            default:    phase_d = phase_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_OFF;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign adv_o   = (phase_d != phase_q);

endmodule

// File: rtl/epd_pin_decode.sv
module epd_pin_decode
  import epd_seq_pkg::*;
(
  input  epd_phase_e phase_i,
  output epd_pins_t  pins_o
);

  // cs is the line level: high = deselected
  always_comb begin
    pins_o = '0;
    unique case (phase_i)
      PH_OFF:     pins_o.off = 1'b1;
      PH_SUPPLY:  pins_o.vcc = 1'b1;
      PH_RST_HI:  begin pins_o.vcc = 1'b1; pins_o.rst = 1'b1; pins_o.cs = 1'b1; end
      PH_RST_LO:  begin pins_o.vcc = 1'b1; pins_o.cs = 1'b1; end
      PH_CS_GAP:  begin pins_o.vcc = 1'b1; pins_o.rst = 1'b1; pins_o.cs = 1'b1; end
      PH_CS_LEAD: begin pins_o.vcc = 1'b1; pins_o.rst = 1'b1; end
      PH_READY:   begin pins_o.vcc = 1'b1; pins_o.rst = 1'b1; pins_o.rdy = 1'b1; end
      PH_HOLD:    pins_o.vcc = 1'b1;
      default:    pins_o.off = 1'b1;
    endcase
  end

endmodule

// File: rtl/epd_pwr_seq.sv
module epd_pwr_seq
  import epd_seq_pkg::*;
#(
  parameter int unsigned SETUP_US  = 10000,
  parameter int unsigned RST_HI_US = 5000,
  parameter int unsigned RST_LO_US = 5000,
  parameter int unsigned CS_GAP_US = 19000,
  parameter int unsigned CS_LEAD_US = 1000,
  parameter int unsigned BUDGET_US = 20000,
  parameter int unsigned HOLD_US   = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pwr_down_i,
  input  logic tick_us_i,
  output logic vcc_en_o,
  output logic reset_o,
  output logic cs_o,
  output logic sdata_o,
  output logic sclk_o,
  output logic ready_o,
  output logic off_o
);

  localparam int unsigned BUDGET_REM = (BUDGET_US > CS_GAP_US) ? (BUDGET_US - CS_GAP_US) : 0;
  localparam int unsigned LEAD_LIM   = max2(CS_LEAD_US, BUDGET_REM);
  localparam int unsigned MAX_LIM    = max2(max2(max2(SETUP_US, RST_HI_US), max2(RST_LO_US, CS_GAP_US)),
                                            max2(LEAD_LIM, HOLD_US));
  localparam int unsigned CW         = (MAX_LIM < 2) ? 1 : $clog2(MAX_LIM + 1);

  epd_phase_e    phase;
  logic          adv;
  logic          done;
  logic [CW-1:0] limit;
  epd_pins_t     pins;

  always_comb begin
    unique case (phase)
      PH_SUPPLY:  limit = CW'(SETUP_US);
      PH_RST_HI:  limit = CW'(RST_HI_US);
      PH_RST_LO:  limit = CW'(RST_LO_US);
      PH_CS_GAP:  limit = CW'(CS_GAP_US);
      PH_CS_LEAD: limit = CW'(LEAD_LIM);
      PH_HOLD:    limit = CW'(HOLD_US);
      default:    limit = '0;
    endcase
  end

  epd_tick_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (adv),
    .tick_i  (tick_us_i),
    .limit_i (limit),
    .done_o  (done)
  );

  epd_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pwr_down_i (pwr_down_i),
    .done_i     (done),
    .phase_o    (phase),
    .adv_o      (adv)
  );

  epd_pin_decode u_dec (
    .phase_i (phase),
    .pins_o  (pins)
  );

  assign vcc_en_o = pins.vcc;
  assign reset_o  = pins.rst;
  assign cs_o     = pins.cs;
  assign ready_o  = pins.rdy;
  assign off_o    = pins.off;
  assign sdata_o  = 1'b0;
  assign sclk_o   = 1'b0;

endmodule

// File: rtl/epd_pwr_seq_chk.sv
module epd_pwr_seq_chk #(
  parameter int unsigned CS_GAP_US = 19000,
  parameter int unsigned BUDGET_US = 20000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_us_i,
  input logic vcc_en_o,
  input logic reset_o,
  input logic cs_o,
  input logic ready_o,
  input logic off_o
);

  // ticks since reset line last went high
  logic [31:0] rel_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rel_cnt <= '0;
    else if (!reset_o)                    rel_cnt <= '0;
    else if (tick_us_i && rel_cnt != '1) rel_cnt <= rel_cnt + 32'd1;
  end

  assert_off_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o |-> (!vcc_en_o && !reset_o && !cs_o && !ready_o));

  assert_supply_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcc_en_o) |-> (!reset_o && !cs_o));

  assert_cs_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_o) && reset_o) |-> (rel_cnt >= 32'(CS_GAP_US)));

  assert_budget_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (rel_cnt >= 32'(BUDGET_US)));

  assert_ready_pins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (vcc_en_o && reset_o && !cs_o));

  assert_drop_to_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> off_o);

endmodule

bind epd_pwr_seq epd_pwr_seq_chk #(.CS_GAP_US(CS_GAP_US), .BUDGET_US(BUDGET_US)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_us_i (tick_us_i),
  .vcc_en_o  (vcc_en_o),
  .reset_o   (reset_o),
  .cs_o      (cs_o),
  .ready_o   (ready_o),
  .off_o     (off_o)
);

// File: tb/epd_pwr_seq_tb.sv
`timescale 1ns/1ps
module epd_pwr_seq_tb;

  localparam int T_SETUP = 10;
  localparam int T_RHI   = 5;
  localparam int T_RLO   = 4;
  localparam int T_GAP   = 8;
  localparam int T_LEAD  = 2;
  localparam int T_BUD   = 14;
  localparam int T_HOLD  = 7;

  localparam logic [4:0] C_OFF  = 5'b00001;
  localparam logic [4:0] C_SUP  = 5'b10000;
  localparam logic [4:0] C_RHI  = 5'b11100;
  localparam logic [4:0] C_RLO  = 5'b10100;
  localparam logic [4:0] C_GAP  = 5'b11100;
  localparam logic [4:0] C_LEAD = 5'b11000;
  localparam logic [4:0] C_RDY  = 5'b11010;
  localparam logic [4:0] C_HOLD = 5'b10000;

  logic clk_i = 1'b0;
  logic rst_ni, start_i, pwr_down_i;
  logic tick_us_i = 1'b0;
  logic vcc_en_o, reset_o, cs_o, sdata_o, sclk_o, ready_o, off_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  epd_pwr_seq #(
    .SETUP_US(T_SETUP), .RST_HI_US(T_RHI), .RST_LO_US(T_RLO), .CS_GAP_US(T_GAP),
    .CS_LEAD_US(T_LEAD), .BUDGET_US(T_BUD), .HOLD_US(T_HOLD)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pwr_down_i(pwr_down_i),
    .tick_us_i(tick_us_i), .vcc_en_o(vcc_en_o), .reset_o(reset_o), .cs_o(cs_o),
    .sdata_o(sdata_o), .sclk_o(sclk_o), .ready_o(ready_o), .off_o(off_o)
  );

  function automatic int exp_lead();
    int rem;
    rem = (T_BUD > T_GAP) ? T_BUD - T_GAP : 0;
    return (T_LEAD > rem) ? T_LEAD : rem;
  endfunction

  function automatic logic [4:0] exp_code(int i);
    case (i)
      0: return C_SUP;
      1: return C_RHI;
      2: return C_RLO;
      3: return C_GAP;
      4: return C_LEAD;
      default: return C_RDY;
    endcase
  endfunction

  function automatic int exp_cnt(int i);
    case (i)
      0: return T_SETUP;
      1: return T_RHI;
      2: return T_RLO;
      3: return T_GAP;
      4: return exp_lead();
      default: return -1;
    endcase
  endfunction

  function automatic string exp_req(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // phase trace: each output change closes a record
  logic [4:0] ph_code [32];
  int         ph_cnt  [32];
  int         n_ph = 0;
  logic [4:0] cur_code = 5'b0;
  int         cur_cnt = 0;
  int         div = 0;
  int         line_err = 0;

  always @(negedge clk_i) begin
    logic [4:0] code;
    code = {vcc_en_o, reset_o, cs_o, ready_o, off_o};
    if (sdata_o !== 1'b0 || sclk_o !== 1'b0) line_err++;
    if (!rst_ni) begin
      cur_code = code;
      cur_cnt  = 0;
    end else if (code != cur_code) begin
      if (n_ph < 32) begin
        ph_code[n_ph] = cur_code;
        ph_cnt[n_ph]  = cur_cnt;
        n_ph++;
      end
      cur_code = code;
      cur_cnt  = 0;
    end else if (tick_us_i) begin
      cur_cnt++;
    end
    div = (div + 1) % 4;
    tick_us_i = (div == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #2;
  endtask

  task automatic pulse_start();
    step(); start_i = 1'b1; step(); start_i = 1'b0;
  endtask

  task automatic pulse_pwr();
    step(); pwr_down_i = 1'b1; step(); pwr_down_i = 1'b0;
  endtask

  task automatic clear_trace();
    step(); n_ph = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ready_o; i++) step();
    repeat (4) step();
  endtask

  task automatic wait_off();
    for (int i = 0; i < 2000 && !off_o; i++) step();
    repeat (8) step();
  endtask

  task automatic bringup_and_verify();
    clear_trace();
    pulse_start();
    wait_ready();
    chk(n_ph == 6 && ph_code[0] == C_OFF, "R2 trace length", n_ph, 6);
    for (int i = 0; i < 5; i++)
      chk(ph_code[i+1] == exp_code(i) && ph_cnt[i+1] == exp_cnt(i), exp_req(i),
          ph_cnt[i+1], exp_cnt(i));
    chk(cur_code == C_RDY, "R7 ready pins", int'(cur_code), int'(C_RDY));
  endtask

  task automatic verify_abort(input int r);
    bit ok;
    int n;
    n = n_ph;
    ok = (n >= 3) && (n <= 8);
    if (ok) begin
      ok = (ph_code[0] == C_OFF) && (ph_code[n-1] == C_HOLD);
      for (int i = 1; i < n - 1; i++) begin
        if (ph_code[i] != exp_code(i-1)) ok = 1'b0;
        if (exp_cnt(i-1) >= 0) begin
          if (i < n - 2 && ph_cnt[i] != exp_cnt(i-1)) ok = 1'b0;
          if (i == n - 2 && ph_cnt[i] > exp_cnt(i-1)) ok = 1'b0;
        end
      end
    end
    chk(ok, "R9 abort prefix", r, n);
    chk(n >= 1 && ph_cnt[n-1] == T_HOLD, "R9 hold length", (n >= 1) ? ph_cnt[n-1] : -1, T_HOLD);
    chk(cur_code == C_OFF, "R9 back to off", int'(cur_code), int'(C_OFF));
  endtask

  initial begin
    #(20.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r;
    rst_ni = 1'b0; start_i = 1'b0; pwr_down_i = 1'b0;
    r = int'($urandom(32'd1357));
    repeat (3) step();
    chk({vcc_en_o, reset_o, cs_o, ready_o, off_o} == C_OFF, "R1 in reset",
        int'({vcc_en_o, reset_o, cs_o, ready_o, off_o}), int'(C_OFF));
    rst_ni = 1'b1;
    repeat (2) step();
    chk({vcc_en_o, reset_o, cs_o, ready_o, off_o} == C_OFF, "R1 after release",
        int'({vcc_en_o, reset_o, cs_o, ready_o, off_o}), int'(C_OFF));

    // R10: power-down alone in off
    clear_trace();
    pulse_pwr();
    repeat (20) step();
    chk(n_ph == 0 && cur_code == C_OFF, "R10 pwr in off", n_ph, 0);

    // R10: power-down wins over start
    clear_trace();
    step(); start_i = 1'b1; pwr_down_i = 1'b1; step(); start_i = 1'b0; pwr_down_i = 1'b0;
    repeat (20) step();
    chk(n_ph == 0 && cur_code == C_OFF, "R10 both in off", n_ph, 0);

    bringup_and_verify();

    // R7: ready holds, start ignored
    clear_trace();
    repeat (30) step();
    pulse_start();
    repeat (10) step();
    chk(n_ph == 0 && cur_code == C_RDY && ready_o, "R7 ready held", n_ph, 0);

    // R8: power-down from ready
    clear_trace();
    pulse_pwr();
    wait_off();
    chk(n_ph == 2 && ph_code[0] == C_RDY && ph_code[1] == C_HOLD && ph_cnt[1] == T_HOLD,
        "R8 hold length", ph_cnt[1], T_HOLD);
    chk(!vcc_en_o && off_o, "R8 supply off", int'(vcc_en_o), 0);

    // R10: start during hold ignored
    bringup_and_verify();
    clear_trace();
    pulse_pwr();
    repeat (12) step();
    pulse_start();
    wait_off();
    repeat (20) step();
    chk(n_ph == 2 && ph_cnt[1] == T_HOLD && cur_code == C_OFF, "R10 start in hold",
        n_ph, 2);

    // R9: random abort points after the supply phase
    for (int k = 0; k < 8; k++) begin
      r = 50 + int'($urandom % 100);
      clear_trace();
      pulse_start();
      repeat (r) step();
      pulse_pwr();
      wait_off();
      verify_abort(r);
    end

    // R1: asynchronous reset mid-sequence
    clear_trace();
    pulse_start();
    repeat (70) step();
    rst_ni = 1'b0;
    step();
    chk({vcc_en_o, reset_o, cs_o, ready_o, off_o} == C_OFF, "R1 mid reset",
        int'({vcc_en_o, reset_o, cs_o, ready_o, off_o}), int'(C_OFF));
    rst_ni = 1'b1;
    repeat (3) step();

    bringup_and_verify();

    chk(line_err == 0, "R11 data and clock low", line_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule